// File: doc/BRIEF.md
# I2C Register-Access Slave

This block is the serial front end of a small configuration and data register file. A bus master reaches the registers over the two-wire I2C bus. SCL and SDA are plain inputs that a fast system clock oversamples. The slave drives SDA only through an open-drain enable, which pulls the line low. It never drives or stretches SCL. The block finds START, repeated START and STOP conditions on the bus. It answers one of two 7-bit addresses, chosen by a select pin.

A write transaction carries a pointer byte first. Bit 7 of the pointer byte turns on auto-increment, and bits 6..0 give the register location. Every later data byte of that transaction is written at the pointer. A read transaction returns bytes starting at the pointer that was last set. The registers themselves live outside the block, behind a simple parallel port. That port carries a write strobe and a read strobe, and the read strobe is one clock wide so that the register file can act on it. The block handles only the top location (16h) internally. Reading it returns an identification byte. Writing a fixed key to it raises a software-reset pulse.

A stalled transaction is abandoned after a programmable number of system clocks. The default count is 25 ms at 50 MHz.

Top module: `i2c_regslave`

## Requirements
- R1: The slave acknowledges an address byte whose 7-bit address is 1001000 when `addr_sel_i` is 0, or 1001001 when it is 1. Any other address gets no acknowledge and causes no register access.
- R2: `addr_sel_i` is sampled at every address byte, not only at reset. After the pin changes, the old address is no longer acknowledged.
- R3: In a write transaction (R/W bit 0), the first byte after the address loads the pointer. Each following byte gives one `reg_wr_o` pulse with `reg_addr_o` equal to the pointer and `reg_wdata_o` equal to the byte. Every byte is acknowledged.
- R4: Pointer bit 7 set to 1 advances the pointer after every data byte written or read. Bit 7 set to 0 keeps the pointer fixed.
- R5: When auto-increment is on, the pointer goes from 16h to 00h.
- R6: A read transaction (R/W bit 1) returns bytes MSB first, starting at the current pointer, with no need to rewrite the pointer. Each byte read from locations 00h..15h gives exactly one `reg_rd_o` pulse, and the byte sent is `reg_rdata_i` in that cycle.
- R7: A not-acknowledge from the master ends the read. SDA is released, and no further `reg_rd_o` pulse follows.
- R8: A repeated START in the middle of a transaction restarts address decoding, so a pointer write can be followed directly by a read.
- R9: If no SCL or SDA edge occurs for `TMO_CYC` system clocks while a transaction is open, the slave releases SDA and returns to idle. A shorter pause has no effect.
- R10: Reading location 16h returns 0001100 with the `addr_sel_i` level as bit 0, that is 18h or 19h. It gives no `reg_rd_o` pulse.
- R11: Writing AAh to location 16h gives a one-cycle `soft_rst_o` pulse and clears the pointer and the increment flag to 0. Any other value written there has no effect.
- R12: Pointer values 17h..7Fh are unimplemented. Writes to them are acknowledged but give no strobe, and reads from them return 00h with no strobe.
- R13: The slave starts pulling SDA low only while SCL is low.
- R14: During and right after reset, SDA is released and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_sel_i | input | 1 | Selects the bus address LSB and the ID LSB |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| reg_wr_o | output | 1 | One-cycle register write strobe |
| reg_rd_o | output | 1 | One-cycle register read strobe |
| reg_addr_o | output | RA_W | Register location (the pointer) |
| reg_wdata_o | output | 8 | Write data |
| reg_rdata_i | input | 8 | Read data for `reg_addr_o`, valid in the strobe cycle |
| soft_rst_o | output | 1 | One-cycle software-reset pulse |

## Verification
The bound checker watches four properties on every cycle. SDA is only ever claimed while SCL is low. The two strobes never overlap, and each is one cycle wide. Strobes only reach implemented locations. The reset pulse stays one cycle wide. Address matching, pointer increment and wrap, data values, the ID byte, the reset key, NACK termination and the timeout are sequence properties across whole bus transactions. Only the bench scenarios can show them, by comparing bus-level acknowledges and read bytes against a register model.

// File: rtl/i2c_regslave_pkg.sv
package i2c_regslave_pkg;

   // bus-side protocol phases of the slave
   typedef enum logic [2:0] {
      LK_IDLE,   // not addressed, waiting for START
      LK_ADDR,   // shifting in address + R/W
      LK_PTR,    // shifting in pointer byte
      LK_WR,     // shifting in data bytes
      LK_ACK,    // slave holds SDA low for the ninth clock
      LK_TX,     // shifting out a read byte
      LK_MACK    // ninth clock of a read, master acknowledges
   } link_st_e;

endpackage

// File: rtl/i2c_regslave_sync.sv
module i2c_regslave_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic level_o,
   output logic rise_o,
   output logic fall_o
);

   logic [STAGES-1:0] chain;
   logic              prev;

   // idle bus level is high, so reset the chain high
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '1;
         prev  <= 1'b1;
      end else begin
         chain <= {chain[STAGES-2:0], line_i};
         prev  <= chain[STAGES-1];
      end
   end

   assign level_o = chain[STAGES-1];
   assign rise_o  = chain[STAGES-1] & ~prev;
   assign fall_o  = ~chain[STAGES-1] & prev;

endmodule

// File: rtl/i2c_regslave_link.sv
module i2c_regslave_link
   import i2c_regslave_pkg::*;
#(
   parameter logic [5:0] DEV_ADDR_HI = 6'b100100,
   parameter int         TMO_CYC     = 1250000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_l,
   input  logic       scl_r,
   input  logic       scl_f,
   input  logic       sda_l,
   input  logic       sda_r,
   input  logic       sda_f,
   input  logic       addr_sel,
   input  logic [7:0] rd_byte,
   output logic       sda_oe_o,
   output logic       ptr_load_o,
   output logic       wr_go_o,
   output logic       rd_go_o,
   output logic [7:0] rx_byte_o
);

   localparam int CW = $clog2(TMO_CYC + 1);

   link_st_e   st, nxt;
   logic [3:0] bitcnt;
   logic [7:0] shreg, txreg;
   logic       ack_ok;
   logic [CW-1:0] tmo;

   logic start_c, stop_c, tmo_hit, any_edge, go, last_rx;
   logic [7:0] byte_now;

   assign start_c  = sda_f & scl_l;
   assign stop_c   = sda_r & scl_l;
   assign any_edge = scl_r | scl_f | sda_r | sda_f;
   assign tmo_hit  = (st != LK_IDLE) && (tmo == CW'(TMO_CYC - 1));
   assign go       = ~start_c & ~stop_c & ~tmo_hit;
   assign byte_now = {shreg[6:0], sda_l};
   assign last_rx  = scl_r && (bitcnt == 4'd7);

   assign rx_byte_o  = byte_now;
   assign ptr_load_o = go && (st == LK_PTR) && last_rx;
   assign wr_go_o    = go && (st == LK_WR)  && last_rx;
   assign rd_go_o    = go && scl_f &&
                       (((st == LK_ACK) && (nxt == LK_TX)) || (st == LK_MACK));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= LK_IDLE;
         nxt      <= LK_IDLE;
         bitcnt   <= '0;
         shreg    <= '0;
         txreg    <= '0;
         ack_ok   <= 1'b0;
         sda_oe_o <= 1'b0;
         tmo      <= '0;
      end else begin
         if ((st == LK_IDLE) || any_edge) tmo <= '0;
         else                             tmo <= tmo + 1'b1;

         if (start_c) begin
            st       <= LK_ADDR;
            bitcnt   <= '0;
            sda_oe_o <= 1'b0;
         end else if (stop_c || tmo_hit) begin
            st       <= LK_IDLE;
            sda_oe_o <= 1'b0;
         end else begin
            unique case (st)
               LK_ADDR, LK_PTR, LK_WR: begin
                  if (scl_r) begin
                     shreg  <= byte_now;
                     bitcnt <= bitcnt + 1'b1;
                     if (bitcnt == 4'd7) begin
                        if (st == LK_ADDR) begin
                           ack_ok <= (byte_now[7:1] == {DEV_ADDR_HI, addr_sel});
                           nxt    <= byte_now[0] ? LK_TX : LK_PTR;
                        end else begin
                           ack_ok <= 1'b1;
                           nxt    <= LK_WR;
                        end
                     end
                  end else if (scl_f && (bitcnt == 4'd8)) begin
                     if (ack_ok) begin
                        sda_oe_o <= 1'b1;
                        st       <= LK_ACK;
                     end else begin
                        st <= LK_IDLE;
                     end
                  end
               end
               LK_ACK: begin
                  if (scl_f) begin
                     bitcnt <= '0;
                     st     <= nxt;
                     if (nxt == LK_TX) begin
                        txreg    <= rd_byte;
                        sda_oe_o <= ~rd_byte[7];
                     end else begin
                        sda_oe_o <= 1'b0;
                     end
                  end
               end
               LK_TX: begin
                  if (scl_r) begin
                     bitcnt <= bitcnt + 1'b1;
                  end else if (scl_f) begin
                     if (bitcnt == 4'd8) begin
                        sda_oe_o <= 1'b0;
                        st       <= LK_MACK;
                     end else begin
                        txreg    <= txreg << 1;
                        sda_oe_o <= ~txreg[6];
                     end
                  end
               end
               LK_MACK: begin
                  if (scl_r && sda_l) begin
                     st <= LK_IDLE;
                  end else if (scl_f) begin
                     txreg    <= rd_byte;
                     sda_oe_o <= ~rd_byte[7];
                     bitcnt   <= '0;
                     st       <= LK_TX;
                  end
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/i2c_regslave_ptr.sv
module i2c_regslave_ptr #(
   parameter int         RA_W     = 5,
   parameter logic [6:0] LAST_REG = 7'h16,
   parameter logic [7:0] RST_KEY  = 8'hAA,
   parameter logic [6:0] ID_HI    = 7'b0001100
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            addr_sel,
   input  logic            ptr_load,
   input  logic            wr_go,
   input  logic            rd_go,
   input  logic [7:0]      rx_byte,
   output logic [7:0]      rd_byte_o,
   output logic            reg_wr_o,
   output logic            reg_rd_o,
   output logic [RA_W-1:0] reg_addr_o,
   output logic [7:0]      reg_wdata_o,
   input  logic [7:0]      reg_rdata_i,
   output logic            soft_rst_o
);

   logic [6:0] ptr, ptr_nxt;
   logic       inc;
   logic       is_reg, is_id, key_hit;

   assign is_reg  = ptr < LAST_REG;
   assign is_id   = ptr == LAST_REG;
   assign key_hit = wr_go && is_id && (rx_byte == RST_KEY);
   assign ptr_nxt = (ptr >= LAST_REG) ? 7'd0 : ptr + 7'd1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
         inc <= 1'b0;
      end else if (ptr_load) begin
         inc <= rx_byte[7];
         ptr <= rx_byte[6:0];
      end else if (key_hit) begin
         inc <= 1'b0;
         ptr <= '0;
      end else if ((wr_go || rd_go) && inc) begin
         ptr <= ptr_nxt;
      end
   end

   assign rd_byte_o   = is_id  ? {ID_HI, addr_sel} :
                        is_reg ? reg_rdata_i : 8'h00;
   assign reg_wr_o    = wr_go && is_reg;
   assign reg_rd_o    = rd_go && is_reg;
   assign reg_addr_o  = ptr[RA_W-1:0];
   assign reg_wdata_o = rx_byte;
   assign soft_rst_o  = key_hit;

endmodule

// File: rtl/i2c_regslave.sv
module i2c_regslave #(
   parameter logic [5:0] DEV_ADDR_HI = 6'b100100,
   parameter int         SYNC_STAGES = 2,
   parameter int         TMO_CYC     = 1250000,
   parameter int         RA_W        = 5,
   parameter logic [6:0] LAST_REG    = 7'h16,
   parameter logic [7:0] RST_KEY     = 8'hAA,
   parameter logic [6:0] ID_HI       = 7'b0001100
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            scl_i,
   input  logic            sda_i,
   input  logic            addr_sel_i,
   output logic            sda_oe_o,
   output logic            reg_wr_o,
   output logic            reg_rd_o,
   output logic [RA_W-1:0] reg_addr_o,
   output logic [7:0]      reg_wdata_o,
   input  logic [7:0]      reg_rdata_i,
   output logic            soft_rst_o
);

   localparam int NLINES = 2;   // index 0 = SCL, 1 = SDA

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (TMO_CYC < 64) begin : g_bad_tmo
      $error("TMO_CYC too small for any bus rate");
   end
   if (int'(LAST_REG) >= (1 << RA_W)) begin : g_bad_ra
      $error("RA_W too narrow for LAST_REG");
   end

   logic [NLINES-1:0] raw, lvl, rs, fl;
   assign raw = {sda_i, scl_i};

   for (genvar g = 0; g < NLINES; g++) begin : g_line
      i2c_regslave_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk     (clk),
         .rst_n   (rst_n),
         .line_i  (raw[g]),
         .level_o (lvl[g]),
         .rise_o  (rs[g]),
         .fall_o  (fl[g])
      );
   end

   logic       ptr_load, wr_go, rd_go;
   logic [7:0] rx_byte, rd_byte;

   i2c_regslave_link #(
      .DEV_ADDR_HI (DEV_ADDR_HI),
      .TMO_CYC     (TMO_CYC)
   ) u_link (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_l      (lvl[0]),
      .scl_r      (rs[0]),
      .scl_f      (fl[0]),
      .sda_l      (lvl[1]),
      .sda_r      (rs[1]),
      .sda_f      (fl[1]),
      .addr_sel   (addr_sel_i),
      .rd_byte    (rd_byte),
      .sda_oe_o   (sda_oe_o),
      .ptr_load_o (ptr_load),
      .wr_go_o    (wr_go),
      .rd_go_o    (rd_go),
      .rx_byte_o  (rx_byte)
   );

   i2c_regslave_ptr #(
      .RA_W     (RA_W),
      .LAST_REG (LAST_REG),
      .RST_KEY  (RST_KEY),
      .ID_HI    (ID_HI)
   ) u_ptr (
      .clk         (clk),
      .rst_n       (rst_n),
      .addr_sel    (addr_sel_i),
      .ptr_load    (ptr_load),
      .wr_go       (wr_go),
      .rd_go       (rd_go),
      .rx_byte     (rx_byte),
      .rd_byte_o   (rd_byte),
      .reg_wr_o    (reg_wr_o),
      .reg_rd_o    (reg_rd_o),
      .reg_addr_o  (reg_addr_o),
      .reg_wdata_o (reg_wdata_o),
      .reg_rdata_i (reg_rdata_i),
      .soft_rst_o  (soft_rst_o)
   );

endmodule

// File: rtl/i2c_regslave_chk.sv
module i2c_regslave_chk #(
   parameter int         RA_W     = 5,
   parameter logic [6:0] LAST_REG = 7'h16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            scl_i,
   input logic            sda_oe_o,
   input logic            reg_wr_o,
   input logic            reg_rd_o,
   input logic [RA_W-1:0] reg_addr_o,
   input logic            soft_rst_o
);

   // R13
   oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe_o && !$past(sda_oe_o)) |-> !scl_i);

   // R6
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr_o && reg_rd_o));

   // R3
   wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_o |-> (7'(reg_addr_o) < LAST_REG));

   // R12
   rd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd_o |-> (7'(reg_addr_o) < LAST_REG));

   // R7
   rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd_o |=> !reg_rd_o);

   // R11
   rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst_o |=> !soft_rst_o);

   // R14
   always @(posedge clk) begin
      if (!rst_n) begin
         reset_quiet_chk: assert (!sda_oe_o && !reg_wr_o && !reg_rd_o);
      end
   end

endmodule

bind i2c_regslave i2c_regslave_chk #(.RA_W(RA_W), .LAST_REG(LAST_REG)) u_chk (.*);

// File: tb/tb_i2c_regslave.sv
module tb_i2c_regslave;

   localparam int CLK_PERIOD = 10;
   localparam int Q          = 8;      // system clocks per quarter SCL period
   localparam int TMO        = 2000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       sda_m = 1'b1;
   logic       sel = 1'b0;
   logic       sda;
   logic       sda_oe, reg_wr, reg_rd, soft_rst;
   logic [4:0] reg_addr;
   logic [7:0] reg_wdata, reg_rdata;

   logic [7:0] regs [32];
   int         wr_cnt, rd_cnt, rst_cnt, bad_drive;
   int         n_chk = 0, n_err = 0;
   bit         done = 1'b0;
   logic       oe_prev;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign sda       = sda_m & ~sda_oe;
   assign reg_rdata = regs[reg_addr];

   i2c_regslave #(.TMO_CYC(TMO)) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_i       (scl),
      .sda_i       (sda),
      .addr_sel_i  (sel),
      .sda_oe_o    (sda_oe),
      .reg_wr_o    (reg_wr),
      .reg_rd_o    (reg_rd),
      .reg_addr_o  (reg_addr),
      .reg_wdata_o (reg_wdata),
      .reg_rdata_i (reg_rdata),
      .soft_rst_o  (soft_rst)
   );

   // register file model and strobe counters
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 32; i++) regs[i] <= 8'(8'h40 + i);
         wr_cnt <= 0; rd_cnt <= 0; rst_cnt <= 0; bad_drive <= 0;
         oe_prev <= 1'b0;
      end else begin
         if (reg_wr) begin
            regs[reg_addr] <= reg_wdata;
            wr_cnt <= wr_cnt + 1;
         end
         if (reg_rd)   rd_cnt  <= rd_cnt + 1;
         if (soft_rst) rst_cnt <= rst_cnt + 1;
         if (sda_oe && !oe_prev && scl) bad_drive <= bad_drive + 1;
         oe_prev <= sda_oe;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wq(input int n);
      repeat (n*Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b0; wq(2); scl = 1'b0; wq(1);
   endtask

   task automatic bus_restart();
      wq(1); sda_m = 1'b1; wq(1); scl = 1'b1; wq(2);
      sda_m = 1'b0; wq(2); scl = 1'b0; wq(1);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wq(1); scl = 1'b1; wq(2); sda_m = 1'b1; wq(2);
   endtask

   task automatic bits8(input logic [7:0] b);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; wq(1); scl = 1'b1; wq(2); scl = 1'b0; wq(1);
      end
   endtask

   task automatic send(input logic [7:0] b, output logic ak);
      bits8(b);
      sda_m = 1'b1; wq(1); scl = 1'b1; wq(1); ak = ~sda; wq(1); scl = 1'b0; wq(1);
   endtask

   task automatic recv(input bit give_ack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         wq(1); scl = 1'b1; wq(1); b[i] = sda; wq(1); scl = 1'b0;
      end
      wq(1); sda_m = give_ack ? 1'b0 : 1'b1; wq(1); scl = 1'b1; wq(2); scl = 1'b0;
      wq(1); sda_m = 1'b1;
   endtask

   task automatic wr1(input logic [6:0] a, input logic [7:0] p, input logic [7:0] d, input string req);
      logic ak;
      bus_start();
      send({a, 1'b0}, ak); check({req, " addr ack"}, ak, 1);
      send(p, ak);         check({req, " ptr ack"}, ak, 1);
      send(d, ak);         check({req, " data ack"}, ak, 1);
      bus_stop();
   endtask

   task automatic rd_at(input logic [6:0] a, input logic [7:0] p, output logic [7:0] b);
      logic ak;
      bus_start();
      send({a, 1'b0}, ak);
      send(p, ak);
      bus_restart();
      send({a, 1'b1}, ak);
      recv(1'b0, b);
      bus_stop();
   endtask

   // sel, pointer byte, data
   localparam logic [16:0] VEC [6] = '{
      {1'b0, 8'h02, 8'hA5},
      {1'b1, 8'h0A, 8'h3C},
      {1'b0, 8'h13, 8'h00},
      {1'b1, 8'h00, 8'hFF},
      {1'b0, 8'h15, 8'h81},
      {1'b1, 8'h11, 8'h5A}
   };

   initial begin
      logic       ak;
      logic [7:0] b;
      int         w0, r0, s0;

      repeat (5) @(negedge clk);
      // R14 reset state
      check("R14 sda released in reset", sda_oe, 0);
      check("R14 no strobes in reset", {reg_wr, reg_rd, soft_rst}, 0);
      rst_n = 1'b1;
      wq(2);
      check("R14 sda released after reset", sda_oe, 0);

      // table: single write then read-back, both address variants (R1 R2 R3 R6)
      foreach (VEC[k]) begin
         sel = VEC[k][16];
         wq(1);
         w0 = wr_cnt; r0 = rd_cnt;
         wr1({6'b100100, sel}, VEC[k][15:8], VEC[k][7:0], "R1 R3 table");
         check("R3 one write strobe", wr_cnt - w0, 1);
         check("R3 register written", regs[VEC[k][12:8]], VEC[k][7:0]);
         rd_at({6'b100100, sel}, VEC[k][15:8], b);
         check("R6 read back", b, VEC[k][7:0]);
         check("R6 one read strobe", rd_cnt - r0, 1);
      end

      // R2: sel high, old address 1001000 ignored
      sel = 1'b1; wq(1);
      w0 = wr_cnt;
      bus_start(); send(8'h90, ak); bus_stop();
      check("R2 stale address not acked", ak, 0);
      // R1: sel low, address 1001001 ignored, no access
      sel = 1'b0; wq(1);
      bus_start(); send(8'h92, ak); send(8'h05, ak); send(8'h77, ak); bus_stop();
      check("R1 foreign address not acked", ak, 0);
      check("R1 no write on foreign address", wr_cnt - w0, 0);

      // R4 increment write
      bus_start(); send(8'h90, ak); send(8'h83, ak);
      send(8'h11, ak); send(8'h22, ak); send(8'h33, ak); bus_stop();
      check("R4 inc write reg3", regs[3], 8'h11);
      check("R4 inc write reg4", regs[4], 8'h22);
      check("R4 inc write reg5", regs[5], 8'h33);

      // R4 increment read, R8 repeated START, R7 NACK end
      r0 = rd_cnt;
      bus_start(); send(8'h90, ak); send(8'h83, ak);
      bus_restart();
      send(8'h91, ak); check("R8 read addr acked after restart", ak, 1);
      recv(1'b1, b); check("R4 inc read 1", b, 8'h11);
      recv(1'b1, b); check("R4 inc read 2", b, 8'h22);
      recv(1'b0, b); check("R4 inc read 3", b, 8'h33);
      check("R7 sda released after nack", sda_oe, 0);
      bus_stop();
      check("R7 no extra read strobe", rd_cnt - r0, 3);

      // R4 fixed pointer
      bus_start(); send(8'h90, ak); send(8'h07, ak);
      send(8'h44, ak); send(8'h55, ak); bus_stop();
      check("R4 fixed ptr last byte wins", regs[7], 8'h55);
      check("R4 fixed ptr neighbour untouched", regs[8], 8'h48);
      // R6 read without rewriting pointer
      bus_start(); send(8'h91, ak);
      recv(1'b1, b); check("R6 read at old ptr 1", b, 8'h55);
      recv(1'b0, b); check("R6 read at old ptr 2", b, 8'h55);
      bus_stop();

      // R5 wrap 16h to 00h, non-key write to 16h ignored
      s0 = rst_cnt;
      bus_start(); send(8'h90, ak); send(8'h95, ak);
      send(8'h61, ak); send(8'h62, ak); send(8'h63, ak); bus_stop();
      check("R5 byte at 15h", regs[5'h15], 8'h61);
      check("R5 wrapped to 00h", regs[0], 8'h63);
      check("R11 non-key no reset", rst_cnt - s0, 0);

      // R10 ID byte, both pin levels
      r0 = rd_cnt;
      sel = 1'b0; wq(1);
      rd_at(7'h48, 8'h16, b); check("R10 id sel low", b, 8'h18);
      sel = 1'b1; wq(1);
      rd_at(7'h49, 8'h16, b); check("R10 id sel high", b, 8'h19);
      check("R10 no strobe for id", rd_cnt - r0, 0);

      // R11 key write
      sel = 1'b0; wq(1);
      w0 = wr_cnt;
      wr1(7'h48, 8'h96, 8'hAA, "R11 key");
      check("R11 one reset pulse", rst_cnt - s0, 1);
      check("R11 no write strobe", wr_cnt - w0, 0);
      bus_start(); send(8'h91, ak);
      recv(1'b1, b); check("R11 ptr cleared", b, 8'h63);
      recv(1'b0, b); check("R11 inc cleared", b, 8'h63);
      bus_stop();

      // R12 unimplemented locations
      w0 = wr_cnt; r0 = rd_cnt;
      wr1(7'h48, 8'h1A, 8'h55, "R12 unimpl");
      check("R12 no write strobe", wr_cnt - w0, 0);
      rd_at(7'h48, 8'h7F, b);
      check("R12 reads zero", b, 8'h00);
      check("R12 no read strobe", rd_cnt - r0, 0);

      // R9 timeout while slave holds ACK
      bus_start(); bits8(8'h90); wq(1);
      check("R9 ack held", sda_oe, 1);
      repeat (TMO/2) @(negedge clk);
      check("R9 short pause no effect", sda_oe, 1);
      repeat (TMO) @(negedge clk);
      check("R9 released after timeout", sda_oe, 0);
      sda_m = 1'b1; wq(1); scl = 1'b1; wq(4);
      wr1(7'h48, 8'h01, 8'hC3, "R9 recovery");
      check("R9 write after recovery", regs[1], 8'hC3);

      check("R13 sda claimed only with scl low", bad_drive, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (180000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule